// File: doc/BRIEF.md
# USB Host Controller Bring-Up Sequencer

This block powers a single USB host controller up and down through one control register on a simple register-access port. Three one-cycle command pulses are accepted: init, which sets the coherency and byte-order bits once after reset; enable, which stages the clock enable and the block enable with a one-millisecond pause after each and then polls the controller's reset-done bit; and disable, which drops both enables in one write. All waits come from a microsecond tick built from a clock-cycles-per-microsecond parameter. A millisecond is a parameter number of these ticks.

Each reset-done poll is a pair of reads. The first read is thrown away, because a read that directly follows other activity can return stale data. Only the second read is evaluated. After a failed poll the sequencer waits one millisecond and polls again. A poll limit bounds the wait and reports a timeout. A single input tells the block whether the controller's reference clock is available. Init and enable are refused while it is low.

Top module: `hc_bringup_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, timeout_o and acc_valid_o are low, and the held register image is zero.
- R2: Init writes the image with bit 1 (coherency) set and bit 0 (big-endian) set only when BIG_ENDIAN is 1. It then waits CYC_PER_US*US_PER_MS cycles before done_o.
- R3: When ref_ok_i is low at acceptance, init and enable make no register access, and done_o pulses with err_o high. err_o holds until the next accepted command.
- R4: Enable first writes bit 3 (clock enable) alone, waits one millisecond, then writes bits 3 and 2 (block enable) together, and waits one millisecond.
- R5: Every poll is two reads. The first read's data is ignored, and bit 4 of the second read decides. When that bit is 1, done_o pulses with timeout_o low.
- R6: After a failed evaluated read, the next poll starts only after a one-millisecond wait.
- R7: After POLL_LIMIT failed evaluated reads, the sequence ends with done_o and timeout_o high. timeout_o holds until the next accepted command.
- R8: Disable makes exactly one write, which clears bits 3 and 2 and keeps bits 1 and 0. done_o follows with no wait.
- R9: acc_valid_o stays high, with write flag and write data stable, until acc_ack_i. No step advances before its access is acknowledged.
- R10: busy_o is high from the cycle after a running sequence is accepted until its end. done_o is a one-cycle pulse with busy_o low. Commands given while busy_o is high are ignored.
- R11: When several commands arrive together while idle, disable wins over enable, and enable wins over init.
- R12: A command given in the cycle done_o is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_init_i | input | 1 | Init command pulse |
| cmd_en_i | input | 1 | Enable command pulse |
| cmd_dis_i | input | 1 | Disable command pulse |
| ref_ok_i | input | 1 | Reference clock available |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last command refused for missing reference |
| timeout_o | output | 1 | Last enable gave up waiting for reset-done |
| acc_valid_o | output | 1 | Register access request |
| acc_write_o | output | 1 | 1 = write, 0 = read |
| acc_addr_o | output | ADDR_W | Control register address |
| acc_wdata_o | output | DATA_W | Write data |
| acc_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| acc_ack_i | input | 1 | Access acknowledge |

## Verification
Two things can land in one cycle: the done_o pulse that ends a sequence, and a new command on the inputs. The bench drives a disable in exactly the cycle it sees done_o after an enable. It then expects busy_o in the next cycle and a single clearing write. The bench also pulses commands in the middle of a running enable, and judges from the access log that they left no trace. Acknowledge latency is random, so each wait is measured from the acknowledge to the next request.

// File: rtl/hc_seq_pkg.sv
package hc_seq_pkg;
  localparam int BIT_BE    = 0;
  localparam int BIT_COH   = 1;
  localparam int BIT_BLK   = 2;
  localparam int BIT_CLK   = 3;
  localparam int BIT_RDONE = 4;
  localparam int IMG_W     = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT_WR,
    ST_INIT_WT,
    ST_CLK_WR,
    ST_CLK_WT,
    ST_BLK_WR,
    ST_BLK_WT,
    ST_POLL_DUMMY,
    ST_POLL_EVAL,
    ST_POLL_WT,
    ST_DIS_WR
  } seq_state_e;
endpackage

// File: rtl/hc_us_tick.sv
module hc_us_tick #(
  parameter int CYC_PER_US = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/hc_wait_timer.sv
module hc_wait_timer #(
  parameter int CYC_PER_US = 48,
  parameter int US_PER_MS  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int UW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [UW-1:0] LAST_US = UW'(US_PER_MS - 1);

  logic          active_q;
  logic [UW-1:0] us_q;
  logic          tick;

  hc_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active_q),
    .tick_o(tick)
  );

  assign expire_o = active_q && tick && (us_q == LAST_US);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      us_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      us_q     <= '0;
    end else if (expire_o) begin
      active_q <= 1'b0;
    end else if (active_q && tick) begin
      us_q <= us_q + 1'b1;
    end
  end
endmodule

// File: rtl/hc_bus_port.sv
module hc_bus_port #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              cmp_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              acc_valid_o,
  output logic              acc_write_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] acc_wdata_o,
  input  logic [DATA_W-1:0] acc_rdata_i,
  input  logic              acc_ack_i
);
  logic              valid_q, write_q, cmp_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      cmp_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      cmp_q <= 1'b0;
      if (valid_q) begin
        if (acc_ack_i) begin
          valid_q <= 1'b0;
          cmp_q   <= 1'b1;
          rdata_q <= acc_rdata_i;
        end
      end else if (req_i) begin
        valid_q <= 1'b1;
        write_q <= req_write_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign cmp_o       = cmp_q;
  assign rdata_o     = rdata_q;
  assign acc_valid_o = valid_q;
  assign acc_write_o = write_q;
  assign acc_addr_o  = CTRL_ADDR;
  assign acc_wdata_o = wdata_q;
endmodule

// File: rtl/hc_bringup_seq.sv
module hc_bringup_seq
  import hc_seq_pkg::*;
#(
  parameter int                CYC_PER_US = 48,
  parameter int                US_PER_MS  = 1000,
  parameter int                POLL_LIMIT = 16,
  parameter bit                BIG_ENDIAN = 1'b0,
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'hFFFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_init_i,
  input  logic              cmd_en_i,
  input  logic              cmd_dis_i,
  input  logic              ref_ok_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              timeout_o,
  output logic              acc_valid_o,
  output logic              acc_write_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] acc_wdata_o,
  input  logic [DATA_W-1:0] acc_rdata_i,
  input  logic              acc_ack_i
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);
  localparam logic [IMG_W-1:0] M_CLK = IMG_W'(1 << BIT_CLK);
  localparam logic [IMG_W-1:0] M_BLK = IMG_W'(1 << BIT_BLK);
  localparam logic [IMG_W-1:0] M_COH = IMG_W'(1 << BIT_COH);
  localparam logic [IMG_W-1:0] M_BE  = BIG_ENDIAN ? IMG_W'(1 << BIT_BE) : '0;

  seq_state_e     state_q;
  logic [IMG_W-1:0] img_q, img_nxt;
  logic           issued_q;
  logic [PW-1:0]  poll_q;
  logic           done_q, err_q, to_q;

  logic              acc_st, wait_st, req, req_write, wait_start, expire, cmp, step_done;
  logic [DATA_W-1:0] rd_word;
  logic              unused_rd;

  assign unused_rd = ^rd_word;

  always_comb begin
    acc_st = 1'b0;
    wait_st = 1'b0;
    unique case (state_q)
      ST_INIT_WR, ST_CLK_WR, ST_BLK_WR,
      ST_POLL_DUMMY, ST_POLL_EVAL, ST_DIS_WR: acc_st = 1'b1;
      ST_INIT_WT, ST_CLK_WT, ST_BLK_WT, ST_POLL_WT: wait_st = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_INIT_WR: img_nxt = img_q | M_COH | M_BE;
      ST_CLK_WR:  img_nxt = img_q | M_CLK;
      ST_BLK_WR:  img_nxt = img_q | M_CLK | M_BLK;
      ST_DIS_WR:  img_nxt = img_q & ~(M_CLK | M_BLK);
      default:    img_nxt = img_q;
    endcase
  end

  assign req        = acc_st && !issued_q;
  assign wait_start = wait_st && !issued_q;
  assign req_write  = !(state_q == ST_POLL_DUMMY || state_q == ST_POLL_EVAL);
  assign step_done  = acc_st ? cmp : (wait_st && expire);

  hc_bus_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .req_write_i(req_write),
    .req_wdata_i(DATA_W'(img_nxt)),
    .cmp_o      (cmp),
    .rdata_o    (rd_word),
    .acc_valid_o(acc_valid_o),
    .acc_write_o(acc_write_o),
    .acc_addr_o (acc_addr_o),
    .acc_wdata_o(acc_wdata_o),
    .acc_rdata_i(acc_rdata_i),
    .acc_ack_i  (acc_ack_i)
  );

  hc_wait_timer #(
    .CYC_PER_US(CYC_PER_US), .US_PER_MS(US_PER_MS)
  ) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wait_start),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      img_q    <= '0;
      issued_q <= 1'b0;
      poll_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step_done)              issued_q <= 1'b0;
      else if (req || wait_start) issued_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          if (cmd_init_i || cmd_en_i || cmd_dis_i) begin
            err_q  <= 1'b0;
            to_q   <= 1'b0;
            poll_q <= '0;
            if (cmd_dis_i)      state_q <= ST_DIS_WR;
            else if (!ref_ok_i) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end
            else if (cmd_en_i)  state_q <= ST_CLK_WR;
            else                state_q <= ST_INIT_WR;
          end
        end
        ST_INIT_WR: if (cmp) begin img_q <= img_nxt; state_q <= ST_INIT_WT; end
        ST_INIT_WT: if (expire) begin state_q <= ST_IDLE; done_q <= 1'b1; end
        ST_CLK_WR:  if (cmp) begin img_q <= img_nxt; state_q <= ST_CLK_WT; end
        ST_CLK_WT:  if (expire) state_q <= ST_BLK_WR;
        ST_BLK_WR:  if (cmp) begin img_q <= img_nxt; state_q <= ST_BLK_WT; end
        ST_BLK_WT:  if (expire) state_q <= ST_POLL_DUMMY;
        ST_POLL_DUMMY: if (cmp) state_q <= ST_POLL_EVAL;  // stale read, data dropped
        ST_POLL_EVAL: if (cmp) begin
          if (rd_word[BIT_RDONE]) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (poll_q == POLL_LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            to_q    <= 1'b1;
          end else begin
            poll_q  <= poll_q + 1'b1;
            state_q <= ST_POLL_WT;
          end
        end
        ST_POLL_WT: if (expire) state_q <= ST_POLL_DUMMY;
        ST_DIS_WR:  if (cmp) begin img_q <= img_nxt; state_q <= ST_IDLE; done_q <= 1'b1; end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/hc_bringup_seq_chk.sv
module hc_bringup_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_init_i,
  input logic              cmd_en_i,
  input logic              cmd_dis_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              timeout_o,
  input logic              acc_valid_o,
  input logic              acc_write_o,
  input logic [DATA_W-1:0] acc_wdata_o,
  input logic              acc_ack_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && !acc_ack_i) |=> (acc_valid_o && $stable(acc_write_o) && $stable(acc_wdata_o))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !acc_valid_o); // R10

  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (cmd_init_i || cmd_en_i || cmd_dis_i)) |=> (busy_o || done_o)); // R12

  AST_REFUSED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !acc_valid_o); // R3

  AST_TIMEOUT_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o); // R7

  AST_BLK_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && acc_write_o && acc_wdata_o[2]) |-> acc_wdata_o[3]); // R4
endmodule

bind hc_bringup_seq hc_bringup_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_init_i (cmd_init_i),
  .cmd_en_i   (cmd_en_i),
  .cmd_dis_i  (cmd_dis_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .timeout_o  (timeout_o),
  .acc_valid_o(acc_valid_o),
  .acc_write_o(acc_write_o),
  .acc_wdata_o(acc_wdata_o),
  .acc_ack_i  (acc_ack_i)
);

// File: tb/hc_bringup_seq_test.sv
module hc_bringup_seq_test;
  localparam int CYC = 2, USM = 5, LIM = 4, W = CYC * USM, SL = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c_init = 0, c_en = 0, c_dis = 0, ref_ok = 1;
  logic busy, done, err, tmo, vld, wr, ack = 0;
  logic [15:0] addr;
  logic [31:0] wdat, rdat = 0;

  always #2.5 clk = ~clk;

  hc_bringup_seq #(
    .CYC_PER_US(CYC), .US_PER_MS(USM), .POLL_LIMIT(LIM), .BIG_ENDIAN(1'b1)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_init_i(c_init), .cmd_en_i(c_en),
    .cmd_dis_i(c_dis), .ref_ok_i(ref_ok), .busy_o(busy), .done_o(done),
    .err_o(err), .timeout_o(tmo), .acc_valid_o(vld), .acc_write_o(wr),
    .acc_addr_o(addr), .acc_wdata_o(wdat), .acc_rdata_i(rdat), .acc_ack_i(ack)
  );

  int cyc = 0, n_chk = 0, n_bad = 0;
  int tr_n = 0, rd_no = 0, ok_after = 1, done_cyc = 0;
  logic tr_wr [32];
  logic [31:0] tr_dat [32];
  int tr_req [32], tr_ack [32];
  logic [3:0] sh = 4'h0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int v, input int lo, input int hi);
    n_chk++;
    if (v < lo || v > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, v, lo, hi);
    end
  endtask

  // bus responder: random acknowledge latency, logs every access
  initial begin
    bit pend = 0;
    int lat = 0;
    logic [31:0] d0 = 0;
    forever begin
      @(negedge clk);
      if (ack) ack = 0;
      else if (vld) begin
        if (!pend) begin
          pend = 1; lat = $urandom % 4; d0 = wdat;
          if (tr_n < 32) tr_req[tr_n] = cyc;
        end
        if (lat == 0) begin
          chk("R9 data stable until ack", wdat, d0);
          if (!wr) begin
            if (rd_no % 2 == 0) rdat = 32'h10 | ($urandom & 32'hFFE0);
            else rdat = ((rd_no / 2 + 1) >= ok_after) ? 32'h10 : ($urandom & 32'hFFEF);
            rd_no++;
          end
          ack = 1;
          if (tr_n < 32) begin
            tr_wr[tr_n] = wr; tr_dat[tr_n] = wdat; tr_ack[tr_n] = cyc; tr_n++;
          end
          pend = 0;
        end else lat--;
      end
    end
  end

  task automatic wait_done(output bit hung);
    int t0 = cyc;
    hung = 0;
    while (!done) begin
      @(negedge clk);
      if (cyc - t0 > 2000) begin hung = 1; break; end
    end
    if (hung) begin n_chk++; n_bad++; $display("FAIL watchdog actual=hung expected=done"); end
    done_cyc = cyc;
  endtask

  task automatic launch(input logic i, input logic e, input logic d, input logic r, input int okn);
    @(negedge clk);
    tr_n = 0; rd_no = 0; ok_after = okn; ref_ok = r;
    c_init = i; c_en = e; c_dis = d;
    @(negedge clk);
    c_init = 0; c_en = 0; c_dis = 0;
  endtask

  task automatic verify(input logic i, input logic e, input logic d, input logic r, input int okn);
    int nreal;
    if (d) begin
      chk("R8 disable one write", tr_n, 1);
      chk("R8 disable data", tr_dat[0], {28'h0, sh & 4'b0011});
      chk("R8 disable is write", tr_wr[0], 1);
      chk_rng("R8 disable no wait", done_cyc - tr_ack[0], 0, SL);
      chk("R11 no error on disable", err, 0);
      sh = sh & 4'b0011;
    end else if (!r) begin
      chk("R3 refused no access", tr_n, 0);
      chk("R3 refused err", err, 1);
    end else if (e) begin
      nreal = (okn > LIM) ? LIM : okn;
      chk("R5 access count", tr_n, 2 + 2 * nreal);
      chk("R4 clock enable alone", tr_dat[0], {28'h0, sh | 4'b1000});
      chk("R4 clock and block enable", tr_dat[1], {28'h0, sh | 4'b1100});
      chk_rng("R4 first wait", tr_req[1] - tr_ack[0], W, W + SL);
      chk_rng("R4 second wait", tr_req[2] - tr_ack[1], W, W + SL);
      for (int k = 0; k < nreal; k++) begin
        chk("R5 poll reads", {tr_wr[2 + 2 * k], tr_wr[3 + 2 * k]}, 2'b00);
        chk_rng("R5 paired reads back to back", tr_req[3 + 2 * k] - tr_ack[2 + 2 * k], 0, SL);
        if (k > 0) chk_rng("R6 wait between polls", tr_req[2 + 2 * k] - tr_ack[1 + 2 * k], W, W + SL);
      end
      chk("R7 timeout flag", tmo, (okn > LIM));
      chk("R5 no error", err, 0);
      sh = sh | 4'b1100;
    end else begin
      chk("R2 init one write", tr_n, 1);
      chk("R2 init data", tr_dat[0], {28'h0, sh | 4'b0011});
      chk_rng("R2 init wait", done_cyc - tr_ack[0], W, W + SL);
      sh = sh | 4'b0011;
    end
    chk("R10 busy low at done", busy, 0);
  endtask

  task automatic run(input logic i, input logic e, input logic d, input logic r, input int okn);
    bit hung;
    launch(i, e, d, r, okn);
    wait_done(hung);
    if (!hung) verify(i, e, d, r, okn);
  endtask

  initial begin
    bit hung;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
    chk("R1 timeout", tmo, 0); chk("R1 valid", vld, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {busy, done, vld}, 3'b000);

    run(1, 0, 0, 0, 1);                       // R3 init refused
    repeat (5) @(negedge clk);
    chk("R3 err held", err, 1);
    run(1, 0, 0, 1, 1);                       // R2, also clears err
    chk("R3 err cleared", err, 0);
    run(0, 1, 0, 1, 1);                       // R4 R5
    run(0, 0, 1, 1, 1);                       // R8
    run(0, 1, 0, 1, 3);                       // R6, dummy reads return 1
    run(0, 1, 0, 1, LIM + 2);                 // R7 timeout
    repeat (4) @(negedge clk);
    chk("R7 timeout held", tmo, 1);
    run(0, 1, 0, 0, 1);                       // R3 enable refused
    chk("R7 timeout cleared", tmo, 0);
    run(1, 1, 1, 1, 1);                       // R11 disable wins
    run(1, 1, 0, 1, 1);                       // R11 enable beats init

    // R10 commands while busy are ignored
    launch(0, 1, 0, 1, 2);
    repeat (4) @(negedge clk);
    c_dis = 1; c_init = 1; @(negedge clk); c_dis = 0; c_init = 0;
    wait_done(hung);
    if (!hung) verify(0, 1, 0, 1, 2);
    repeat (3) @(negedge clk);
    chk("R10 ignored command left no access", {busy, vld, 6'(tr_n)}, {2'b00, 6'd6});

    // R12 command in the done cycle
    launch(0, 1, 0, 1, 1);
    wait_done(hung);
    if (!hung) verify(0, 1, 0, 1, 1);
    c_dis = 1; @(negedge clk); c_dis = 0;
    chk("R12 accepted in done cycle", busy, 1);
    tr_n = 0;
    wait_done(hung);
    if (!hung) verify(0, 0, 1, 1, 1);

    for (int n = 0; n < 40; n++) begin
      int k = $urandom % 3;
      run(k == 0, k == 1, k == 2, ($urandom % 4) != 0, 1 + $urandom % (LIM + 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule